// File: doc/BRIEF.md
# Banked Register File and Return Stack Addressing

This block sits beside an instruction decoder and owns a small on-chip data RAM of at least 64 bytes. It turns a register number 0–7 into a RAM address for whichever of two register banks is active. It follows pointer registers 0 and 1 of the active bank for indirect access. It keeps the status byte, which holds the carry, auxiliary carry, a user flag, the bank select and a 3-bit stack pointer. Calls and interrupts push the 12-bit program counter and the upper status nibble into an eight-level stack inside the same RAM. Returns pop them.

Each cycle the decoder raises at most one request. The request is a register access (direct or indirect, read or write), a push, a pop (plain or status-restoring), a bank select, or a status write. Read data and a popped program counter appear one cycle after the request. The status nibble reloaded by a restoring pop appears one cycle after that.

The RAM is built as two byte lanes, even and odd addresses. A push writes its two-byte stack entry in a single cycle, and each lane stays a plain single-port memory.

Top module: `bank_stack_core`

## Requirements
- R1: After synchronous reset, `psw_out` reads 8'h08: the flags are clear, bank 0 is selected and the stack pointer is 0.
- R2: A direct access to register n (0–7) uses RAM address n when `psw_out[4]` is 0 and address 24+n when it is 1. Read data shows on `acc_rdata` in the cycle after the request.
- R3: A `bank_set` request copies `bank_val` into `psw_out[4]`. The new bank governs every register access that follows.
- R4: A `psw_we` request loads `psw_in` bits 7–4 and 2–0 into the status byte. `psw_out[3]` always reads 1 whatever is written.
- R5: An indirect access uses as its RAM address the active bank's register 0 (`acc_sel[0]`=0) or register 1 (`acc_sel[0]`=1), reduced modulo the RAM size.
- R6: A push stores `pc_in[7:0]` at address 8+2·SP and {status bits 7–4, `pc_in[11:8]`} at the next address, then increments SP.
- R7: A pop decrements SP, then reads the entry at 8+2·SP. `pc_out` equals the stored 12-bit PC from the cycle after the pop.
- R8: A restoring pop (`pop` with `pop_psw`=1) reloads status bits 7–4 from the popped entry one cycle after `pc_out` updates. The SP bits keep the decremented value.
- R9: SP counts modulo 8 and has no overflow detection. A ninth push overwrites level 0, and the next pop returns that ninth PC.
- R10: A plain pop (`pop_psw`=0) leaves status bits 7–3 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Register/RAM access request |
| acc_ind | input | 1 | 1: indirect through pointer register; 0: direct register |
| acc_sel | input | 3 | Register number (direct) or pointer choice in bit 0 (indirect) |
| acc_we | input | 1 | 1: write, 0: read |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, valid the cycle after a read |
| push | input | 1 | Push PC and status nibble |
| pop | input | 1 | Pop a stack entry |
| pop_psw | input | 1 | With `pop`: also restore status bits 7–4 |
| pc_in | input | 12 | Program counter to push |
| pc_out | output | 12 | Popped program counter |
| bank_set | input | 1 | Bank select request |
| bank_val | input | 1 | Bank to select |
| psw_we | input | 1 | Status write request |
| psw_in | input | 8 | Status value to write |
| psw_out | output | 8 | Status byte (bit 3 reads 1) |

## Verification
The assertions assume the decoder raises at most one of `acc_en`, `push`, `pop`, `bank_set` and `psw_we` per cycle. They also assume no `psw_we` or `bank_set` falls in the cycle right after a restoring pop, because that cycle carries the reload. The stimulus issues each request as a single-cycle pulse followed by an idle cycle, so both conditions always hold. Random requests include pops whose restored nibble flips the bank. Before any random traffic, every RAM byte is written through the ports so that no read returns uninitialised data.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  localparam int unsigned PC_W      = 12;
  localparam int unsigned HI_W      = 4;
  localparam int unsigned SP_W      = 3;
  localparam int unsigned SEL_W     = 3;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned LEVELS    = 1 << SP_W;
  localparam int unsigned PTR_REGS  = 2;
  localparam int unsigned BANKS     = 2;
  typedef logic [DATA_W-1:0] byte_t;
endpackage

// File: rtl/bsc_status.sv
module bsc_status
  import bsc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic             pop_psw,
  input  logic             psw_we,
  input  byte_t            psw_in,
  input  logic             bank_set,
  input  logic             bank_val,
  input  logic [HI_W-1:0]  restore_hi,
  output logic [SP_W-1:0]  sp,
  output logic [HI_W-1:0]  hi_bits,
  output byte_t            psw_out
);
  logic [SP_W-1:0] sp_q;
  logic [HI_W-1:0] hi_q;
  logic            restore_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q      <= '0;
      hi_q      <= '0;
      restore_q <= 1'b0;
    end else begin
      restore_q <= pop & pop_psw;
      if (psw_we) begin
        hi_q <= psw_in[7:4];
        sp_q <= psw_in[SP_W-1:0];
      end else if (bank_set) begin
        hi_q[0] <= bank_val;
      end else if (push) begin
        sp_q <= sp_q + 1'b1;
      end else if (pop) begin
        sp_q <= sp_q - 1'b1;
      end
      if (restore_q) hi_q <= restore_hi;
    end
  end

  assign sp      = sp_q;
  assign hi_bits = hi_q;
  assign psw_out = {hi_q, 1'b1, sp_q};

  a_r6_push_increments: assert property (@(posedge clk) disable iff (rst)
    (push && !restore_q) |=> (sp_q == $past(sp_q) + 1'b1));
  a_r7_pop_decrements: assert property (@(posedge clk) disable iff (rst)
    (pop && !restore_q) |=> (sp_q == $past(sp_q) - 1'b1));
  a_r3_bank_follows: assert property (@(posedge clk) disable iff (rst)
    (bank_set && !restore_q) |=> (psw_out[4] == $past(bank_val)));
  a_r10_plain_pop_keeps_flags: assert property (@(posedge clk) disable iff (rst)
    (pop && !pop_psw && !restore_q) |=> $stable(hi_q));
endmodule

// File: rtl/bsc_addr.sv
module bsc_addr
  import bsc_pkg::*;
#(
  parameter int AW         = 6,
  parameter int BANK1_BASE = 24,
  parameter int STACK_BASE = 8,
  localparam int LAW       = AW - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bank,
  input  logic [SP_W-1:0]  sp,
  input  logic [HI_W-1:0]  hi_bits,
  input  logic             acc_en,
  input  logic             acc_ind,
  input  logic [SEL_W-1:0] acc_sel,
  input  logic             acc_we,
  input  byte_t            acc_wdata,
  input  logic             push,
  input  logic             pop,
  input  logic [PC_W-1:0]  pc_in,
  output logic [LAW-1:0]   lane_idx,
  output logic             we_even,
  output logic             we_odd,
  output byte_t            wd_even,
  output byte_t            wd_odd,
  output logic             rd_en,
  output logic             acc_odd
);
  byte_t           ptr_q [BANKS][PTR_REGS];
  logic [AW-1:0]   bank_base;
  logic [AW-1:0]   acc_addr;
  logic [SP_W-1:0] sp_eff;
  logic            acc_wr;

  always_comb begin
    bank_base = bank ? AW'(BANK1_BASE) : '0;
    if (acc_ind) acc_addr = ptr_q[bank][acc_sel[0]][AW-1:0];
    else         acc_addr = bank_base + AW'(acc_sel);
    sp_eff = push ? sp : sp - 1'b1;
    if (push || pop) lane_idx = LAW'(STACK_BASE / 2) + LAW'(sp_eff);
    else             lane_idx = acc_addr[AW-1:1];
    acc_wr  = acc_en & acc_we;
    we_even = push | (acc_wr & ~acc_addr[0]);
    we_odd  = push | (acc_wr & acc_addr[0]);
    wd_even = push ? pc_in[7:0] : acc_wdata;
    wd_odd  = push ? {hi_bits, pc_in[PC_W-1:8]} : acc_wdata;
    rd_en   = pop | (acc_en & ~acc_we);
    acc_odd = acc_addr[0];
  end

  // Shadow copies of the pointer registers, kept write-through with the RAM
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < BANKS; b++)
        for (int i = 0; i < PTR_REGS; i++)
          ptr_q[b][i] <= '0;
    end else if (acc_wr) begin
      for (int b = 0; b < BANKS; b++)
        for (int i = 0; i < PTR_REGS; i++)
          if (acc_addr == AW'(b * BANK1_BASE + i)) ptr_q[b][i] <= acc_wdata;
    end
  end

  a_r6_stack_window: assert property (@(posedge clk) disable iff (rst)
    (push || pop) |-> (lane_idx >= LAW'(STACK_BASE / 2)) &&
                      (lane_idx <  LAW'(STACK_BASE / 2 + LEVELS)));
  a_r2_bank1_window: assert property (@(posedge clk) disable iff (rst)
    (acc_en && !acc_ind && bank) |-> (acc_addr >= AW'(BANK1_BASE)) &&
                                     (acc_addr <  AW'(BANK1_BASE + 8)));
endmodule

// File: rtl/bsc_ram.sv
module bsc_ram
  import bsc_pkg::*;
#(
  parameter int LAW   = 5,
  localparam int DEPTH = 1 << LAW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [LAW-1:0] idx,
  input  logic           rd_en,
  input  logic           we_even,
  input  logic           we_odd,
  input  byte_t          wd_even,
  input  byte_t          wd_odd,
  output byte_t          rd_even,
  output byte_t          rd_odd
);
  logic  [1:0] we_l;
  byte_t       wd_l [2];
  byte_t       rd_l [2];

  assign we_l    = {we_odd, we_even};
  assign wd_l[0] = wd_even;
  assign wd_l[1] = wd_odd;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    byte_t mem [DEPTH];
    byte_t rd_q;
    always_ff @(posedge clk) begin
      if (we_l[g]) mem[idx] <= wd_l[g];
    end
    always_ff @(posedge clk) begin
      if (rst)        rd_q <= '0;
      else if (rd_en) rd_q <= mem[idx];
    end
    assign rd_l[g] = rd_q;
  end

  assign rd_even = rd_l[0];
  assign rd_odd  = rd_l[1];
endmodule

// File: rtl/bank_stack_core.sv
module bank_stack_core
  import bsc_pkg::*;
#(
  parameter int RAM_BYTES  = 64,
  parameter int BANK1_BASE = 24,
  parameter int STACK_BASE = 8,
  localparam int AW        = $clog2(RAM_BYTES),
  localparam int LAW       = AW - 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        acc_en,
  input  logic        acc_ind,
  input  logic [2:0]  acc_sel,
  input  logic        acc_we,
  input  logic [7:0]  acc_wdata,
  output logic [7:0]  acc_rdata,
  input  logic        push,
  input  logic        pop,
  input  logic        pop_psw,
  input  logic [11:0] pc_in,
  output logic [11:0] pc_out,
  input  logic        bank_set,
  input  logic        bank_val,
  input  logic        psw_we,
  input  logic [7:0]  psw_in,
  output logic [7:0]  psw_out
);
  logic [SP_W-1:0] sp;
  logic [HI_W-1:0] hi_bits;
  logic [LAW-1:0]  lane_idx;
  logic            we_even, we_odd, rd_en, acc_odd, odd_q;
  byte_t           wd_even, wd_odd, rd_even, rd_odd;

  bsc_status u_status (
    .clk, .rst, .push, .pop, .pop_psw, .psw_we, .psw_in,
    .bank_set, .bank_val,
    .restore_hi (rd_odd[7:4]),
    .sp, .hi_bits, .psw_out
  );

  bsc_addr #(.AW(AW), .BANK1_BASE(BANK1_BASE), .STACK_BASE(STACK_BASE)) u_addr (
    .clk, .rst,
    .bank (hi_bits[0]),
    .sp, .hi_bits, .acc_en, .acc_ind, .acc_sel, .acc_we, .acc_wdata,
    .push, .pop, .pc_in, .lane_idx, .we_even, .we_odd, .wd_even, .wd_odd,
    .rd_en, .acc_odd
  );

  bsc_ram #(.LAW(LAW)) u_ram (
    .clk, .rst, .idx (lane_idx), .rd_en, .we_even, .we_odd,
    .wd_even, .wd_odd, .rd_even, .rd_odd
  );

  always_ff @(posedge clk) begin
    if (rst)                     odd_q <= 1'b0;
    else if (acc_en && !acc_we)  odd_q <= acc_odd;
  end

  assign acc_rdata = odd_q ? rd_odd : rd_even;
  assign pc_out    = {rd_odd[PC_W-9:0], rd_even};

  a_r7_one_request: assert property (@(posedge clk) disable iff (rst)
    $onehot0({acc_en, push, pop, bank_set, psw_we}));
  a_r6_push_both_lanes: assert property (@(posedge clk) disable iff (rst)
    push |-> (we_even && we_odd && !rd_en));
endmodule

// File: tb/bank_stack_core_test.sv
module bank_stack_core_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        acc_en, acc_ind, acc_we, push, pop, pop_psw, bank_set, bank_val, psw_we;
  logic [2:0]  acc_sel;
  logic [7:0]  acc_wdata, acc_rdata, psw_in, psw_out;
  logic [11:0] pc_in, pc_out;

  int errs = 0;
  int checks = 0;
  logic [7:0] mem_m [64];
  logic [7:0] psw_m;

  always #10 clk = ~clk;

  bank_stack_core uut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_in();
    acc_en = 0; acc_ind = 0; acc_we = 0; acc_sel = 0; acc_wdata = 0;
    push = 0; pop = 0; pop_psw = 0; pc_in = 0;
    bank_set = 0; bank_val = 0; psw_we = 0; psw_in = 0;
  endtask

  function automatic logic [5:0] base_m();
    return psw_m[4] ? 6'd24 : 6'd0;
  endfunction

  task automatic reg_op(input logic ind, input logic [2:0] sel, input logic we, input logic [7:0] wd);
    logic [5:0] a;
    a = ind ? mem_m[base_m() + {5'd0, sel[0]}][5:0] : base_m() + {3'd0, sel};
    acc_en = 1; acc_ind = ind; acc_sel = sel; acc_we = we; acc_wdata = wd;
    if (we) mem_m[a] = wd;
    @(negedge clk); clear_in();
    if (!we) chk(ind ? "R5 indirect read" : "R2 direct read", acc_rdata, mem_m[a]);
    @(negedge clk);
    chk("R3 status after access", psw_out, psw_m | 8'h08);
  endtask

  task automatic push_op(input logic [11:0] pc);
    logic [5:0] a;
    a = 6'd8 + {2'd0, psw_m[2:0], 1'b0};
    mem_m[a] = pc[7:0];
    mem_m[a + 1] = {psw_m[7:4], pc[11:8]};
    psw_m[2:0] = psw_m[2:0] + 3'd1;
    push = 1; pc_in = pc;
    @(negedge clk); clear_in();
    @(negedge clk);
    chk("R6 status after push", psw_out, psw_m | 8'h08);
  endtask

  task automatic pop_op(input logic rest);
    logic [5:0] a;
    psw_m[2:0] = psw_m[2:0] - 3'd1;
    a = 6'd8 + {2'd0, psw_m[2:0], 1'b0};
    pop = 1; pop_psw = rest;
    @(negedge clk); clear_in();
    chk("R7 popped pc", pc_out, {mem_m[a + 1][3:0], mem_m[a]});
    if (rest) psw_m[7:4] = mem_m[a + 1][7:4];
    @(negedge clk);
    chk(rest ? "R8 restored status" : "R10 plain pop status", psw_out, psw_m | 8'h08);
  endtask

  task automatic psw_op(input logic [7:0] v);
    psw_m = v & 8'hF7;
    psw_we = 1; psw_in = v;
    @(negedge clk); clear_in();
    @(negedge clk);
    chk("R4 status write", psw_out, psw_m | 8'h08);
  endtask

  task automatic bank_op(input logic v);
    psw_m[4] = v;
    bank_set = 1; bank_val = v;
    @(negedge clk); clear_in();
    @(negedge clk);
    chk("R3 bank select", psw_out, psw_m | 8'h08);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    clear_in();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    psw_m = 8'h00;
    chk("R1 reset status", psw_out, 8'h08);
    @(negedge clk);

    // fill the whole RAM through the ports, pointers last
    for (int a = 63; a >= 2; a--) begin
      reg_op(0, 3'd0, 1, 8'(a));
      reg_op(1, 3'd0, 1, 8'(a * 7 + 3));
    end
    reg_op(0, 3'd1, 1, 8'h11);
    reg_op(0, 3'd0, 1, 8'h22);

    // R4: bit 3 reads 1 even when written 0
    psw_op(8'h00);
    chk("R4 bit3 forced", psw_out, 8'h08);

    // R2: bank 1 register 5 is address 29
    bank_op(1);
    reg_op(0, 3'd5, 1, 8'hC3);
    bank_op(0);
    reg_op(0, 3'd0, 1, 8'd29);
    reg_op(1, 3'd0, 0, 8'h00);
    chk("R2 bank1 r5 at 29", acc_rdata, 8'hC3);

    // R5: pointer 0xC5 wraps to address 5
    reg_op(0, 3'd1, 1, 8'hC5);
    reg_op(1, 3'd1, 1, 8'h5A);
    reg_op(0, 3'd5, 0, 8'h00);
    chk("R5 pointer modulo", acc_rdata, 8'h5A);

    // R9: nine pushes wrap onto level 0
    psw_op(8'h00);
    for (int i = 0; i < 9; i++) push_op(12'h100 + 12'(i));
    chk("R9 sp wrapped", {29'd0, psw_out[2:0]}, 32'd1);
    pop_op(0);
    chk("R9 ninth pc on level 0", pc_out, 12'h108);

    // R8: restore flags and bank, sp keeps the decrement
    psw_op(8'hF0);
    push_op(12'h3AB);
    psw_op(8'h01);
    pop_op(1);
    chk("R8 restored value", psw_out, 8'hF8);
    chk("R7 restored pc", pc_out, 12'h3AB);

    // random traffic
    void'($urandom(32'h5EED_0048));
    for (int n = 0; n < 500; n++) begin
      case ($urandom_range(0, 6))
        0: reg_op(0, 3'($urandom_range(0, 7)), 1, 8'($urandom));
        1: reg_op(0, 3'($urandom_range(0, 7)), 0, 8'h00);
        2: reg_op(1, 3'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 8'($urandom));
        3: push_op(12'($urandom));
        4: pop_op(1'($urandom_range(0, 1)));
        5: bank_op(1'($urandom_range(0, 1)));
        default: psw_op(8'($urandom));
      endcase
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule